// File: doc/BRIEF.md
# Turnaround-Free Synchronous SRAM Model

This block is a cycle-accurate, synthesizable model of a flow-through synchronous SRAM. It accepts a new read or write command on every enabled clock, in any order, with no idle cycle on the data bus. Write data arrives one enabled edge after its address. The model drives nothing during that data cycle, so a read can follow a write, and a write can follow a read, back to back. The array is split into 9-bit byte lanes, each holding 8 data bits and 1 parity bit. Every lane has its own active-low write select.

Commands are loaded with a full address. A burst is continued by holding the advance input high, and each continuation steps the two low address bits through a 4-beat wrap. The wrap runs in linear or interleaved order. A pending write is held in one register stage until the next enabled edge, and a read of that address in the meantime is served from the stage. Holding the clock-enable input high freezes every register in the block.

The pad-side bus is presented as an input vector, an output vector and a single drive enable. A pad ring joins these into one bidirectional bus. The output enable input reaches the drive enable through logic alone, with no register.

Top module: `tfsram`

## Requirements
- R1: After synchronous reset, the drive enable is low and the block is deselected. A burst continuation issued right after reset starts no access.
- R2: A read loaded at an enabled edge presents the addressed word on `dq_o`, with `dq_en` high (when `oe_n` is low), from that edge until the next enabled edge.
- R3: Write data on `dq_i` and the lane selects `bw_n` are sampled at the first enabled edge after the edge that loaded the write. `dq_en` is low during that data cycle.
- R4: Lane l is bits `[9l+8:9l]` of the data word. A write updates lane l only when `bw_n[l]` is 0, and all other lanes keep their old contents.
- R5: A load starts an access only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at that edge. Otherwise the cycle is a deselect: `dq_en` stays low and no word is written.
- R6: An edge with `cke_n` high is ignored entirely. The read output, any pending write and the burst position all hold.
- R7: `oe_n` high forces `dq_en` low at once, without waiting for a clock edge. Bringing it low again restores the pending read output.
- R8: A read loaded at the edge right after a write to the same address returns the newly written lanes merged with the old ones. Reads and writes may alternate on every edge.
- R9: With `adv_ld`=1 the block repeats the direction of the last load. With `order_sel`=0 the low two address bits become (start + n) mod 4 for beat n, and the upper bits keep the loaded value.
- R10: With `order_sel`=1 the low two address bits of beat n are start XOR n.
- R11: During a continuation (`adv_ld`=1), `we_n` and the three chip enables are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| adv_ld | input | 1 | 1 = continue burst, 0 = load new command |
| we_n | input | 1 | Write enable for a load, active low |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low, sampled in the data cycle |
| addr | input | ADDR_W | Word address |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dq_i | input | LANES*9 | Write data from the pad |
| dq_o | output | LANES*9 | Read data to the pad |
| dq_en | output | 1 | Pad drive enable |

## Verification
The burst-step assertion assumes that `order_sel` changes only on an enabled load edge. This means a burst never mixes the two orders. The random stimulus therefore changes the order only on an edge that is enabled and loads. The other properties assume only that the inputs are known at enabled edges. The bench reads an address only after writing it, so every expected word is defined. It also drives `dq_i` with fresh garbage outside the data cycles, which shows that no stray bus value is ever captured.

// File: rtl/tfsram_pkg.sv
package tfsram_pkg;

    localparam int unsigned LANE_BITS = 9;
    localparam int unsigned BURST_LEN = 4;
    localparam int unsigned BEAT_W    = $clog2(BURST_LEN);

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    // Kind of the command held in the address stage.
    typedef struct packed {
        logic valid;
        logic write;
    } op_t;

    // Low address bits of a burst beat.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input burst_order_e      order
    );
        if (order == ORDER_INTERLEAVED) begin
            return start ^ beat;
        end
        return start + beat;
    endfunction

endpackage

// File: rtl/tfsram_cmd.sv
module tfsram_cmd
    import tfsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              order_sel,
    output op_t               op_d,
    output logic [ADDR_W-1:0] addr_d
);

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_nx;
    op_t               last_q;
    burst_order_e      order;

    assign order   = burst_order_e'(order_sel);
    assign beat_nx = beat_q + BEAT_W'(1);

    always_comb begin
        if (!adv_ld) begin
            op_d.valid = sel;
            op_d.write = sel & ~we_n;
            addr_d     = addr;
        end else begin
            op_d   = last_q;
            addr_d = {base_q[ADDR_W-1:BEAT_W],
                      beat_offset(base_q[BEAT_W-1:0], beat_nx, order)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            last_q <= '0;
        end else if (step) begin
            if (!adv_ld) begin
                base_q <= addr;
                beat_q <= '0;
                last_q <= op_d;
            end else begin
                beat_q <= beat_nx;
            end
        end
    end

endmodule

// File: rtl/tfsram_wstage.sv
module tfsram_wstage
    import tfsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
)
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  op_t                          cmd_op,
    input  logic [ADDR_W-1:0]            cmd_addr,
    input  logic [LANES-1:0]             bw_n,
    input  logic [LANES*LANE_BITS-1:0]   dq_i,
    output logic                         pend_valid,
    output logic [ADDR_W-1:0]            pend_addr,
    output logic [LANES*LANE_BITS-1:0]   pend_data,
    output logic [LANES-1:0]             pend_be,
    output logic                         commit
);

    // The pending write retires on the next enabled edge.
    assign commit = step & pend_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_data  <= '0;
            pend_be    <= '0;
        end else if (step) begin
            pend_valid <= cmd_op.valid & cmd_op.write;
            pend_addr  <= cmd_addr;
            pend_data  <= dq_i;
            pend_be    <= ~bw_n;
        end
    end

endmodule

// File: rtl/tfsram_array.sv
module tfsram_array
    import tfsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
)
(
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [LANES-1:0]             wr_be,
    input  logic [LANES*LANE_BITS-1:0]   wr_data,
    input  logic                         fwd_valid,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [LANES*LANE_BITS-1:0]   rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic addr_hit;
    assign addr_hit = fwd_valid && (wr_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_BITS-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g]) begin
                store[wr_addr] <= wr_data[g*LANE_BITS +: LANE_BITS];
            end
        end

        // A lane of the uncommitted write takes the place of the stored lane.
        assign rd_data[g*LANE_BITS +: LANE_BITS] =
            (addr_hit && wr_be[g]) ? wr_data[g*LANE_BITS +: LANE_BITS]
                                   : store[rd_addr];
    end

endmodule

// File: rtl/tfsram.sv
module tfsram
    import tfsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
)
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cke_n,
    input  logic                         adv_ld,
    input  logic                         we_n,
    input  logic                         cs1_n,
    input  logic                         cs2,
    input  logic                         cs3_n,
    input  logic [LANES-1:0]             bw_n,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         order_sel,
    input  logic                         oe_n,
    input  logic [LANES*LANE_BITS-1:0]   dq_i,
    output logic [LANES*LANE_BITS-1:0]   dq_o,
    output logic                         dq_en
);

    localparam int unsigned DATA_W = LANES * LANE_BITS;

    logic              step;
    logic              sel;
    op_t               op_d;
    logic [ADDR_W-1:0] addr_d;
    op_t               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [DATA_W-1:0] pend_data;
    logic [LANES-1:0]  pend_be;
    logic              commit;

    assign step = ~cke_n;
    assign sel  = ~cs1_n & cs2 & ~cs3_n;

    tfsram_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .adv_ld    (adv_ld),
        .we_n      (we_n),
        .sel       (sel),
        .addr      (addr),
        .order_sel (order_sel),
        .op_d      (op_d),
        .addr_d    (addr_d)
    );

    // Address stage: the command captured at the last enabled edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_op   <= '0;
            cmd_addr <= '0;
        end else if (step) begin
            cmd_op   <= op_d;
            cmd_addr <= addr_d;
        end
    end

    tfsram_wstage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wstage (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .bw_n       (bw_n),
        .dq_i       (dq_i),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .pend_data  (pend_data),
        .pend_be    (pend_be),
        .commit     (commit)
    );

    tfsram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk       (clk),
        .wr_en     (commit),
        .wr_addr   (pend_addr),
        .wr_be     (pend_be),
        .wr_data   (pend_data),
        .fwd_valid (pend_valid),
        .rd_addr   (cmd_addr),
        .rd_data   (dq_o)
    );

    // Drive only for a read; a write data cycle or deselect leaves the pad off.
    assign dq_en = ~oe_n & cmd_op.valid & ~cmd_op.write;

endmodule

// File: rtl/tfsram_checker.sv
module tfsram_checker
    import tfsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
)
(
    input logic              clk,
    input logic              rst,
    input logic              cke_n,
    input logic              adv_ld,
    input logic              we_n,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              order_sel,
    input logic              oe_n,
    input logic              dq_en,
    input op_t               cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              pend_valid
);

    logic sel;
    assign sel = ~cs1_n & cs2 & ~cs3_n;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !dq_en);

    assert_read_drive_R2: assert property (@(posedge clk) disable iff (rst)
        !cke_n && !adv_ld && we_n && sel |=> (dq_en || oe_n));

    assert_write_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !cke_n && !adv_ld && !we_n && sel |=> !dq_en);

    assert_late_capture_R3: assert property (@(posedge clk) disable iff (rst)
        !cke_n && cmd_op.valid && cmd_op.write |=> pend_valid);

    assert_deselect_R5: assert property (@(posedge clk) disable iff (rst)
        !cke_n && !adv_ld && !sel |=> (!dq_en && !cmd_op.valid));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> ($stable(cmd_op) && $stable(cmd_addr) && $stable(pend_valid)));

    assert_linear_step_R9: assert property (@(posedge clk) disable iff (rst)
        !cke_n && adv_ld && (order_sel == 1'b0)
        |=> (cmd_addr[1:0] == $past(cmd_addr[1:0]) + 2'd1)
            && (cmd_addr[ADDR_W-1:2] == $past(cmd_addr[ADDR_W-1:2])));

    assert_adv_keeps_dir_R11: assert property (@(posedge clk) disable iff (rst)
        !cke_n && adv_ld |=> (cmd_op == $past(cmd_op)));

endmodule

bind tfsram tfsram_checker #(.ADDR_W(ADDR_W)) u_tfsram_chk (
    .clk        (clk),
    .rst        (rst),
    .cke_n      (cke_n),
    .adv_ld     (adv_ld),
    .we_n       (we_n),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .order_sel  (order_sel),
    .oe_n       (oe_n),
    .dq_en      (dq_en),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .pend_valid (pend_valid)
);

// File: tb/tfsram_bench.sv
module tfsram_bench;
    import tfsram_pkg::*;

    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int DW    = LN * LANE_BITS;
    localparam int DEPTH = 1 << AW;
    localparam int OP_NONE = 0;
    localparam int OP_RD   = 1;
    localparam int OP_WR   = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic          we_n = 1'b1;
    logic          cs1_n = 1'b0;
    logic          cs2 = 1'b0;
    logic          cs3_n = 1'b0;
    logic [LN-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic          order_sel = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_en;

    always #4 clk = ~clk;

    tfsram #(.ADDR_W(AW), .LANES(LN)) u_tfsram (
        .clk(clk), .rst(rst), .cke_n(cke_n), .adv_ld(adv_ld), .we_n(we_n),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .bw_n(bw_n), .addr(addr),
        .order_sel(order_sel), .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
    );

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] exp_mem [DEPTH];
    int            m_op = OP_NONE;
    int            m_last = OP_NONE;
    logic [AW-1:0] m_addr = '0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [LN-1:0] m_bw = '1;

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [LN-1:0] bwn);
        logic [DW-1:0] r = old_w;
        for (int l = 0; l < LN; l++) begin
            if (!bwn[l]) r[l*LANE_BITS +: LANE_BITS] = new_w[l*LANE_BITS +: LANE_BITS];
        end
        return r;
    endfunction

    function automatic logic [DW-1:0] rand_word();
        return DW'({$urandom, $urandom});
    endfunction

    task automatic check_val(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic exp_en;
        exp_en = (m_op == OP_RD) && !oe_n;
        check_val(tag, DW'(dq_en), DW'(exp_en));
        if (exp_en) check_val(tag, dq_o, exp_mem[m_addr]);
    endtask

    // Called at a falling edge: apply one edge's inputs, update the model, check.
    task automatic cyc(input bit stall, input bit adv, input bit wr, input bit sel,
                       input logic [AW-1:0] a, input logic [LN-1:0] bwn,
                       input logic [DW-1:0] wd, input bit ord, input string tag);
        cke_n     = stall;
        adv_ld    = adv;
        we_n      = ~wr;
        cs1_n     = 1'b0;
        cs2       = sel;
        cs3_n     = 1'b0;
        addr      = a;
        order_sel = ord;
        @(posedge clk);
        if (!stall) begin
            if (m_op == OP_WR) exp_mem[m_addr] = merge(exp_mem[m_addr], m_wdata, m_bw);
            if (!adv) begin
                m_op   = sel ? (wr ? OP_WR : OP_RD) : OP_NONE;
                m_last = m_op;
                m_base = a;
                m_beat = 2'd0;
                m_addr = a;
            end else begin
                m_beat = m_beat + 2'd1;
                m_op   = m_last;
                m_addr = {m_base[AW-1:2], ord ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
            end
            if (m_op == OP_WR) begin
                m_wdata = wd;
                m_bw    = bwn;
            end
        end
        #1;
        if (m_op == OP_WR) begin
            dq_i = m_wdata;
            bw_n = m_bw;
        end else begin
            dq_i = rand_word();
            bw_n = LN'($urandom);
        end
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        bit r_ord;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 'x;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_val("R1", DW'(dq_en), DW'(0));
        // Continuation right after reset stays deselected.
        cyc(0, 1, 0, 1, 6'd3, '1, '0, 0, "R1");

        // Fill the array with back-to-back writes.
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, 1, 1, AW'(a), '0, rand_word(), 0, "R3");
        cyc(0, 0, 0, 1, 6'd5, '1, '0, 0, "R2");
        cyc(0, 0, 0, 1, 6'd40, '1, '0, 0, "R2");

        // Partial write then immediate read, then read again after commit.
        cyc(0, 0, 1, 1, 6'd5, 4'b1010, rand_word(), 0, "R3");
        cyc(0, 0, 0, 1, 6'd5, '1, '0, 0, "R8");
        cyc(0, 0, 0, 1, 6'd5, '1, '0, 0, "R4");
        cyc(0, 0, 1, 1, 6'd12, 4'b0110, rand_word(), 0, "R4");
        cyc(0, 0, 0, 1, 6'd12, '1, '0, 0, "R4");

        // Alternate write/read on every edge.
        for (int k = 0; k < 6; k++) begin
            cyc(0, 0, 1, 1, AW'(9 + k), LN'($urandom), rand_word(), 0, "R8");
            cyc(0, 0, 0, 1, AW'(9 + k), '1, '0, 0, "R8");
        end

        // Deselected write and read.
        cyc(0, 0, 1, 0, 6'd6, '0, rand_word(), 0, "R5");
        cyc(0, 0, 0, 0, 6'd6, '1, '0, 0, "R5");
        cyc(0, 0, 0, 1, 6'd6, '1, '0, 0, "R5");

        // Stalls hold the read output and the write data cycle.
        cyc(0, 0, 0, 1, 6'd7, '1, '0, 0, "R6");
        for (int k = 0; k < 3; k++) cyc(1, 0, 1, 1, 6'd20, '0, rand_word(), 0, "R6");
        cyc(0, 0, 1, 1, 6'd8, '0, rand_word(), 0, "R6");
        for (int k = 0; k < 2; k++) cyc(1, 0, 0, 1, 6'd21, '1, '0, 0, "R6");
        cyc(0, 0, 0, 1, 6'd8, '1, '0, 0, "R6");
        cyc(0, 0, 0, 1, 6'd20, '1, '0, 0, "R6");

        // Output enable acts without a clock.
        cyc(0, 0, 0, 1, 6'd11, '1, '0, 0, "R2");
        oe_n = 1'b1;
        #1;
        check_val("R7", DW'(dq_en), DW'(0));
        oe_n = 1'b0;
        #1;
        check_val("R7", DW'(dq_en), DW'(1));
        check_val("R7", dq_o, exp_mem[11]);

        // Linear bursts: write then read starting at low bits 01.
        cyc(0, 0, 1, 1, 6'h21, '0, rand_word(), 0, "R9");
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 6'h00, '0, rand_word(), 0, "R9");
        cyc(0, 0, 0, 1, 6'h21, '1, '0, 0, "R9");
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 6'h00, '1, '0, 0, "R9");
        cyc(0, 0, 0, 1, 6'h12, '1, '0, 0, "R9");
        for (int k = 0; k < 4; k++) cyc(0, 1, 0, 1, 6'h00, '1, '0, 0, "R9");

        // Interleaved burst from low bits 01: 1,0,3,2.
        cyc(0, 0, 1, 1, 6'h0D, '0, rand_word(), 1, "R10");
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 6'h00, '0, rand_word(), 1, "R10");
        cyc(0, 0, 0, 1, 6'h0F, '1, '0, 1, "R10");
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 1, 6'h00, '1, '0, 1, "R10");

        // Continuation ignores write enable and chip enables.
        cyc(0, 0, 0, 1, 6'h14, '1, '0, 0, "R11");
        cyc(0, 1, 1, 0, 6'h3F, '0, rand_word(), 0, "R11");
        cyc(0, 1, 1, 1, 6'h3F, '0, rand_word(), 0, "R11");
        check_val("R11", DW'(dq_en), DW'(1));

        // Constrained random traffic.
        r_ord = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            bit st, ad, w, s;
            st = ($urandom % 10) == 0;
            ad = ($urandom % 4) == 0;
            w  = ($urandom % 2) == 0;
            s  = ($urandom % 10) != 0;
            if (!st && !ad) r_ord = ($urandom % 2) == 1;
            d = rand_word();
            cyc(st, ad, w, s, AW'($urandom), LN'($urandom), d, r_ord, "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule